// File: doc/BRIEF.md
# Keyed Configuration Register Window

This block sits behind a two-byte host I/O window and holds the configuration registers for up to eight logical devices. Offset 0 of the window is the index port and offset 1 is the data port. After reset the window is closed. The host opens it by writing the same key byte to the index port on two consecutive index-port writes. While it is open, the host writes a register index to the index port and then reads or writes that register through the data port. The byte 0xAA written to the index port closes the window again from any state.

A small set of global registers is always visible. These are the device-select register, a fixed two-byte vendor signature and a 16-bit chip identifier. Every other implemented index belongs to the bank of the logical device currently selected. Each bank holds an I/O base address, an interrupt mode register and a FIFO control register. The fields of all banks leave the block as packed output vectors, so that the neighbouring serial-port logic can use them.

The unlock control is a three-state machine:
- **ST_LOCKED** is the reset state. An index-port write of KEY moves it to ST_HALF (transition *first_key*).
- In **ST_HALF**, an index-port write of KEY moves it to ST_OPEN (*second_key*). Any other index-port write returns it to ST_LOCKED (*broken_seq*).
- In **ST_OPEN**, an index-port write of 0xAA returns it to ST_LOCKED (*exit*). The exit byte also returns ST_HALF to ST_LOCKED. Any other index-port write in ST_OPEN latches the index (*select_index*).

Top module: `sio_cfg_window`

## Requirements
- R1: After reset the window is closed, `cfg_open` is 0 and every bank field output is zero. A read of either port returns 0xFF.
- R2: The window opens only after two consecutive index-port writes of the KEY byte. Any other index-port write between them restarts the sequence.
- R3: An index-port write of 0xAA closes the window from any state, including the state in which one key has been seen.
- R4: While the window is closed, data-port writes change no register, and reads of either port return 0xFF.
- R5: When the window is open, index 0x23 reads 0x19 and index 0x24 reads 0x34. Index 0x20 reads CHIP_ID[7:0] and index 0x21 reads CHIP_ID[15:8].
- R6: Index 0x07 holds the device select and reads back as written. Per-device accesses go to the selected bank. When the select value is NDEV or higher, per-device writes are ignored and per-device reads return 0x00.
- R7: Index 0x60 holds bits 15:8 of the selected device's I/O base and index 0x61 holds bits 7:0. The value appears on `dev_iobase[16*d +: 16]`.
- R8: Index 0x70 is the interrupt mode register. Bit 4 drives `dev_irq_share[d]` and bits 6:5 drive `dev_irq_mode[2*d +: 2]` (00 = level/active-low, 01 = edge/active-high). The other bits read as 0.
- R9: Index 0xF6 is FIFO control. Bits 1:0 drive `dev_fifo_depth` (11 = 128 bytes) and bits 5:4 drive `dev_rx_scale`. The other bits read as 0.
- R10: Indices that are not implemented read 0x00 when the window is open, and writes to them change nothing.
- R11: A data-port write takes effect on the clock edge that samples it and not before.
- R12: When the window is open, a read of the index port returns the last latched index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Window offset: 0 = index port, 1 = data port |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high (0x00 otherwise) |
| cfg_open | output | 1 | Window is open |
| dev_iobase | output | 16*NDEV | I/O base address of each device |
| dev_irq_share | output | NDEV | Interrupt sharing enable of each device |
| dev_irq_mode | output | 2*NDEV | Interrupt mode of each device |
| dev_fifo_depth | output | 2*NDEV | FIFO depth mode of each device |
| dev_rx_scale | output | 2*NDEV | Receive threshold scaling of each device |

## Verification
The bench interrupts the key sequence with a foreign byte. A design that only counted key writes would then open the window early, and data reads would return a value other than 0xFF. The exit byte is also written after a single key. A design that kept the half-unlocked state would then open on the very next key. Every bank is written with a distinct pattern and read back. This exposes bank decode errors, which show up as a field on the wrong device's output, and read-mask errors, which let stray bits leak from the interrupt or FIFO registers. The remaining sweeps cover every unimplemented index, an out-of-range device select, and the cycle in which a write first becomes visible.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_HALF   = 2'd1,
        ST_OPEN   = 2'd2
    } unlock_state_e;

    localparam logic [7:0] EXIT_BYTE   = 8'hAA;
    localparam logic [7:0] IDX_DEVSEL  = 8'h07;
    localparam logic [7:0] IDX_CHIP_LO = 8'h20;
    localparam logic [7:0] IDX_CHIP_HI = 8'h21;
    localparam logic [7:0] IDX_VEND_A  = 8'h23;
    localparam logic [7:0] IDX_VEND_B  = 8'h24;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] IDX_IRQ     = 8'h70;
    localparam logic [7:0] IDX_FIFO    = 8'hF6;
    localparam logic [7:0] VEND_A_VAL  = 8'h19;
    localparam logic [7:0] VEND_B_VAL  = 8'h34;
endpackage

// File: rtl/sio_unlock_fsm.sv
module sio_unlock_fsm
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] KEY = 8'h87
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_wr,
    input  logic [7:0] wdata,
    output logic       open,
    output logic       idx_load
);
    unlock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (addr_wr) begin
            unique case (state_q)
                ST_LOCKED: if (wdata == KEY) state_d = ST_HALF;
                ST_HALF:   state_d = (wdata == KEY) ? ST_OPEN : ST_LOCKED;
                ST_OPEN:   if (wdata == EXIT_BYTE) state_d = ST_LOCKED;
                default:   state_d = ST_LOCKED;
            endcase
        end
    end

    always_comb begin
        open     = (state_q == ST_OPEN);
        idx_load = addr_wr && (state_q == ST_OPEN) && (wdata != EXIT_BYTE);
    end

    a_r2_open_needs_second_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(addr_wr && wdata == KEY && state_q == ST_HALF));
    a_r3_exit_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_wr && wdata == EXIT_BYTE) |=> !open);
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
    import sio_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [15:0] iobase,
    output logic        irq_share,
    output logic [1:0]  irq_mode,
    output logic [1:0]  fifo_depth,
    output logic [1:0]  rx_scale
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iobase     <= '0;
            irq_share  <= 1'b0;
            irq_mode   <= 2'b00;
            fifo_depth <= 2'b00;
            rx_scale   <= 2'b00;
        end else if (we) begin
            unique case (idx)
                IDX_BASE_HI: iobase[15:8] <= wdata;
                IDX_BASE_LO: iobase[7:0]  <= wdata;
                IDX_IRQ: begin
                    irq_share <= wdata[4];
                    irq_mode  <= wdata[6:5];
                end
                IDX_FIFO: begin
                    fifo_depth <= wdata[1:0];
                    rx_scale   <= wdata[5:4];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            IDX_BASE_HI: rdata = iobase[15:8];
            IDX_BASE_LO: rdata = iobase[7:0];
            IDX_IRQ:     rdata = {1'b0, irq_mode, irq_share, 4'b0000};
            IDX_FIFO:    rdata = {2'b00, rx_scale, 2'b00, fifo_depth};
            default:     rdata = 8'h00;
        endcase
    end

    a_r7_base_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == IDX_BASE_HI) |=> iobase[15:8] == $past(wdata));
    a_r10_unimpl_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx != IDX_BASE_HI && idx != IDX_BASE_LO && idx != IDX_IRQ && idx != IDX_FIFO)
        |=> ($stable(iobase) && $stable(irq_share) && $stable(irq_mode)
             && $stable(fifo_depth) && $stable(rx_scale)));
endmodule

// File: rtl/sio_cfg_window.sv
module sio_cfg_window
    import sio_cfg_pkg::*;
#(
    parameter int          NDEV    = 8,
    parameter logic [7:0]  KEY     = 8'h87,
    parameter logic [15:0] CHIP_ID = 16'h1010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic               cfg_open,
    output logic [16*NDEV-1:0] dev_iobase,
    output logic [NDEV-1:0]    dev_irq_share,
    output logic [2*NDEV-1:0]  dev_irq_mode,
    output logic [2*NDEV-1:0]  dev_fifo_depth,
    output logic [2*NDEV-1:0]  dev_rx_scale
);
    localparam int         SEL_W  = (NDEV > 1) ? $clog2(NDEV) : 1;
    localparam logic [7:0] NDEV_B = 8'(NDEV);

    logic       idx_load, addr_wr, data_wr, sel_ok, global_idx;
    logic [7:0] index_q, devsel_q;
    logic [7:0] bank_rd [NDEV];

    assign addr_wr    = bus_wr && !bus_addr;
    assign data_wr    = bus_wr && bus_addr && cfg_open;
    assign sel_ok     = devsel_q < NDEV_B;
    assign global_idx = (index_q == IDX_DEVSEL) || (index_q == IDX_CHIP_LO) ||
                        (index_q == IDX_CHIP_HI) || (index_q == IDX_VEND_A) ||
                        (index_q == IDX_VEND_B);

    sio_unlock_fsm #(.KEY(KEY)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_wr  (addr_wr),
        .wdata    (bus_wdata),
        .open     (cfg_open),
        .idx_load (idx_load)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q  <= 8'h00;
            devsel_q <= 8'h00;
        end else begin
            if (idx_load) index_q <= bus_wdata;
            if (data_wr && index_q == IDX_DEVSEL) devsel_q <= bus_wdata;
        end
    end

    for (genvar g = 0; g < NDEV; g++) begin : g_bank
        logic bank_we;
        assign bank_we = data_wr && !global_idx && (devsel_q == 8'(g));
        sio_dev_bank u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .we         (bank_we),
            .idx        (index_q),
            .wdata      (bus_wdata),
            .rdata      (bank_rd[g]),
            .iobase     (dev_iobase[16*g +: 16]),
            .irq_share  (dev_irq_share[g]),
            .irq_mode   (dev_irq_mode[2*g +: 2]),
            .fifo_depth (dev_fifo_depth[2*g +: 2]),
            .rx_scale   (dev_rx_scale[2*g +: 2])
        );
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            if (!cfg_open)      bus_rdata = 8'hFF;
            else if (!bus_addr) bus_rdata = index_q;
            else begin
                unique case (index_q)
                    IDX_DEVSEL:  bus_rdata = devsel_q;
                    IDX_CHIP_LO: bus_rdata = CHIP_ID[7:0];
                    IDX_CHIP_HI: bus_rdata = CHIP_ID[15:8];
                    IDX_VEND_A:  bus_rdata = VEND_A_VAL;
                    IDX_VEND_B:  bus_rdata = VEND_B_VAL;
                    default:     bus_rdata = sel_ok ? bank_rd[devsel_q[SEL_W-1:0]] : 8'h00;
                endcase
            end
        end
    end

    a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && !cfg_open) |=> ($stable(dev_iobase) && $stable(dev_irq_share)
            && $stable(dev_irq_mode) && $stable(dev_fifo_depth) && $stable(dev_rx_scale)));
    a_r6_bad_select_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !sel_ok) |=> $stable(dev_iobase));
    a_r5_vendor_sig: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr && cfg_open && index_q == IDX_VEND_A) |-> bus_rdata == 8'h19);
endmodule

// File: tb/sio_cfg_window_tb.sv
module sio_cfg_window_tb;
    localparam int          NDEV = 8;
    localparam logic [7:0]  KEY  = 8'h87;
    localparam logic [15:0] CHIP = 16'h1010;

    logic clk = 0, rst_n = 0, bus_addr = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic cfg_open;
    logic [16*NDEV-1:0] dev_iobase;
    logic [NDEV-1:0] dev_irq_share;
    logic [2*NDEV-1:0] dev_irq_mode, dev_fifo_depth, dev_rx_scale;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    sio_cfg_window #(.NDEV(NDEV), .KEY(KEY), .CHIP_ID(CHIP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_open(cfg_open),
        .dev_iobase(dev_iobase), .dev_irq_share(dev_irq_share), .dev_irq_mode(dev_irq_mode),
        .dev_fifo_depth(dev_fifo_depth), .dev_rx_scale(dev_rx_scale));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    function automatic logic [15:0] base_of(int d);
        return {8'(8'h10 + d), 8'(d * 37 + 1)};
    endfunction
    function automatic logic [7:0] irq_of(int d);
        return 8'(d * 29 + 3);
    endfunction
    function automatic logic [7:0] fifo_of(int d);
        return 8'(d * 53 + 7);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 open", 32'(cfg_open), 0);
        chk("R1 iobase", 32'(|dev_iobase), 0);
        chk("R1 fields", 32'(|{dev_irq_share, dev_irq_mode, dev_fifo_depth, dev_rx_scale}), 0);
        rd(1, v); chk("R1 data read", 32'(v), 32'hFF);
        // R4 locked: data writes ignored, reads FF
        wr(1, 8'h5A);
        chk("R4 locked write", 32'(|{dev_iobase, dev_irq_mode, dev_fifo_depth}), 0);
        rd(0, v); chk("R4 index read locked", 32'(v), 32'hFF);
        // R2 broken sequence
        wr(0, KEY); wr(0, 8'h55); wr(0, KEY);
        chk("R2 broken seq", 32'(cfg_open), 0);
        rd(1, v); chk("R2 half data read", 32'(v), 32'hFF);
        wr(0, KEY);
        chk("R2 opened", 32'(cfg_open), 1);
        // R5 / R12
        wr(0, 8'h23); rd(0, v); chk("R12 index readback", 32'(v), 32'h23);
        rd(1, v); chk("R5 vendor 23", 32'(v), 32'h19);
        wr(0, 8'h24); rd(1, v); chk("R5 vendor 24", 32'(v), 32'h34);
        wr(0, 8'h20); rd(1, v); chk("R5 chip lo", 32'(v), 32'(CHIP[7:0]));
        wr(0, 8'h21); rd(1, v); chk("R5 chip hi", 32'(v), 32'(CHIP[15:8]));
        // R7 R8 R9 program every bank
        for (int d = 0; d < NDEV; d++) begin
            wr(0, 8'h07); wr(1, 8'(d));
            wr(0, 8'h60); wr(1, base_of(d)[15:8]);
            wr(0, 8'h61); wr(1, base_of(d)[7:0]);
            wr(0, 8'h70); wr(1, irq_of(d));
            wr(0, 8'hF6); wr(1, fifo_of(d));
        end
        for (int d = 0; d < NDEV; d++) begin
            chk("R7 iobase out", 32'(dev_iobase[16*d +: 16]), 32'(base_of(d)));
            chk("R8 share out", 32'(dev_irq_share[d]), 32'(irq_of(d)[4]));
            chk("R8 mode out", 32'(dev_irq_mode[2*d +: 2]), 32'(irq_of(d)[6:5]));
            chk("R9 depth out", 32'(dev_fifo_depth[2*d +: 2]), 32'(fifo_of(d)[1:0]));
            chk("R9 scale out", 32'(dev_rx_scale[2*d +: 2]), 32'(fifo_of(d)[5:4]));
            wr(0, 8'h07); wr(1, 8'(d));
            rd(1, v); chk("R6 select readback", 32'(v), 32'(d));
            wr(0, 8'h60); rd(1, v); chk("R7 base hi read", 32'(v), 32'(base_of(d)[15:8]));
            wr(0, 8'h61); rd(1, v); chk("R7 base lo read", 32'(v), 32'(base_of(d)[7:0]));
            wr(0, 8'h70); rd(1, v); chk("R8 irq read", 32'(v), 32'(irq_of(d) & 8'h70));
            wr(0, 8'hF6); rd(1, v); chk("R9 fifo read", 32'(v), 32'(fifo_of(d) & 8'h33));
        end
        // R11 timing: select dev 2, write base hi
        wr(0, 8'h07); wr(1, 8'd2); wr(0, 8'h60);
        @(negedge clk);
        bus_addr = 1; bus_wdata = 8'hC5; bus_wr = 1;
        #2 chk("R11 before edge", 32'(dev_iobase[32 +: 16]), 32'(base_of(2)));
        @(negedge clk); bus_wr = 0;
        chk("R11 after edge", 32'(dev_iobase[32 +: 16]), 32'({8'hC5, base_of(2)[7:0]}));
        // R6 out-of-range select
        wr(0, 8'h07); wr(1, 8'(NDEV + 1));
        wr(0, 8'h61); wr(1, 8'hEE);
        chk("R6 bad select no write", 32'(dev_iobase[0 +: 16]), 32'(base_of(0)));
        rd(1, v); chk("R6 bad select read", 32'(v), 0);
        // R10 unimplemented sweep on dev 0
        wr(0, 8'h07); wr(1, 8'd0);
        for (int i = 0; i < 256; i++) begin
            if (i == 8'h07 || i == 8'h20 || i == 8'h21 || i == 8'h23 || i == 8'h24 ||
                i == 8'h60 || i == 8'h61 || i == 8'h70 || i == 8'hF6 || i == 8'hAA) continue;
            wr(0, 8'(i)); wr(1, 8'hC3);
            rd(1, v); chk("R10 unimpl read", 32'(v), 0);
        end
        chk("R10 dev0 base kept", 32'(dev_iobase[0 +: 16]), 32'(base_of(0)));
        chk("R10 dev0 fifo kept", 32'(dev_fifo_depth[1:0]), 32'(fifo_of(0)[1:0]));
        // R3 exit from open and from half state
        wr(0, 8'hAA);
        chk("R3 exit open", 32'(cfg_open), 0);
        wr(0, 8'h60); wr(1, 8'h00);
        chk("R4 write after exit", 32'(dev_iobase[0 +: 16]), 32'(base_of(0)));
        rd(1, v); chk("R4 read after exit", 32'(v), 32'hFF);
        wr(0, KEY); wr(0, 8'hAA); wr(0, KEY);
        chk("R3 exit from half", 32'(cfg_open), 0);
        wr(0, KEY);
        chk("R3 reopen", 32'(cfg_open), 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule